// File: doc/BRIEF.md
# Shutoff Synchronizer Latch

This block turns a set of asynchronous shutoff candidates into one clean, clock-aligned shutoff flag per output channel. For each channel a 3-bit selector picks the shutoff source from two timer inputs, four auxiliary inputs or a constant. An optional inversion is applied after the selector. A 2-bit policy field then decides how the flag is set and released. The policies are: disabled, sticky until software clears it, released by a chosen signal edge, or following the source level directly.

All external level inputs pass through a two-stage synchronizer before they are used. Edges are found by comparing the synchronized value with its value one clock earlier. Software releases a sticky flag by pulsing a per-channel clear request in the same cycle as a shared write-enable. Whenever a set and a release fall in the same cycle, the set is kept.

Top module: `shutoff_latch`

## Requirements
- R1: Source select codes per channel: 0 timer input 0, 1 timer input 1, 2 aux input 2, 3 aux input 3, 4 aux input 0, 5 aux input 1, 6 constant 0, 7 constant 1.
- R2: When the channel's invert bit is 1, the selected source is inverted before the policy uses it.
- R3: In mode 2'b00 the flag is cleared on the next clock edge and stays 0 whatever the source does.
- R4: In mode 2'b01 an active source sets the flag. The flag then stays set after the source goes inactive, until a software clear occurs.
- R5: A software clear acts only when the channel's clear-request bit and the shared write-enable are both 1 in the same cycle; either one alone leaves the flag unchanged.
- R6: In mode 2'b10 an active source sets the flag, and the flag clears on the edge picked by the 2-bit edge select: 0 falling edge of the own channel input, 1 rising edge of the own channel input, 2 falling edge of the preceding-stage input, 3 rising edge of the preceding-stage input.
- R7: In mode 2'b10, edges of the wrong direction on the selected input and edges on the non-selected input do not clear the flag.
- R8: In mode 2'b11 the flag equals the (possibly inverted) source: 1 while it is active, 0 while it is inactive.
- R9: When a set condition and a clear event happen in the same cycle, the flag ends up set.
- R10: A change on an external input reaches the flag on the third rising clock edge after the change and not before. A change of constant source, inversion, mode or software clear takes effect on the next edge.
- R11: While reset is asserted, and directly after it is released, every flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tmrIn | input | 2 | Timer shutoff inputs 0 and 1 |
| auxIn | input | 4 | Auxiliary shutoff inputs 0 to 3 |
| chanIn | input | NUM_CH | Own channel input, one per channel, used for release edges |
| prevIn | input | NUM_CH | Preceding-stage input, one per channel, used for release edges |
| srcSel | input | NUM_CH x 3 | Per-channel shutoff source select |
| srcInv | input | NUM_CH | Per-channel source inversion |
| mode | input | NUM_CH x 2 | Per-channel set/clear policy |
| edgeSel | input | NUM_CH x 2 | Per-channel release edge select |
| swRst | input | NUM_CH | Per-channel software clear request strobe |
| swWe | input | 1 | Write enable that qualifies the software clear |
| shutFlag | output | NUM_CH | Synchronized shutoff flag per channel |

## Verification
The flag is the only visible state, so a wrong decode of the source or polarity shows on the port within three edges in the following mode. A release decoder that watches the wrong input or direction leaves a sticky flag set, or drops it, on the first edge that should or should not release it. That difference is visible three edges after the driving input toggles. A broken synchronizer depth moves every reaction by a whole cycle, so it is caught by sampling both one edge before and on the expected edge.

// File: rtl/shutoff_latch_pkg.sv
package shutoff_latch_pkg;

  localparam int unsigned TMR_W   = 2;
  localparam int unsigned AUX_W   = 4;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MODE_W  = 2;
  localparam int unsigned EDGE_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    LATCH_OFF      = 2'd0,
    LATCH_STICKY   = 2'd1,
    LATCH_EDGE_REL = 2'd2,
    LATCH_FOLLOW   = 2'd3
  } latchMode_t;

  typedef enum logic [EDGE_W-1:0] {
    REL_OWN_FALL  = 2'd0,
    REL_OWN_RISE  = 2'd1,
    REL_PREV_FALL = 2'd2,
    REL_PREV_RISE = 2'd3
  } relEdge_t;

  // control -> datapath strobes
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
  } flagCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic srcActive;
    logic relEdge;
  } chanStat_t;

endpackage

// File: rtl/shutoff_sync.sv
module shutoff_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) begin
        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/shutoff_datapath.sv
module shutoff_datapath
  import shutoff_latch_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [TMR_W-1:0]              tmrIn,
  input  logic [AUX_W-1:0]              auxIn,
  input  logic [NUM_CH-1:0]             chanIn,
  input  logic [NUM_CH-1:0]             prevIn,
  input  logic [NUM_CH-1:0][SEL_W-1:0]  srcSel,
  input  logic [NUM_CH-1:0]             srcInv,
  input  logic [NUM_CH-1:0][EDGE_W-1:0] edgeSel,
  input  flagCmd_t [NUM_CH-1:0]         cmd,
  output chanStat_t [NUM_CH-1:0]        stat,
  output logic [NUM_CH-1:0]             flagQ
);

  localparam int unsigned RAW_W    = TMR_W + AUX_W + 2 * NUM_CH;
  localparam int unsigned AUX_LO   = TMR_W;
  localparam int unsigned CHAN_LO  = TMR_W + AUX_W;
  localparam int unsigned PREV_LO  = CHAN_LO + NUM_CH;

  logic [RAW_W-1:0]  rawBus;
  logic [RAW_W-1:0]  syncBus;
  logic [TMR_W-1:0]  tmrS;
  logic [AUX_W-1:0]  auxS;
  logic [NUM_CH-1:0] chanS;
  logic [NUM_CH-1:0] prevS;
  logic [NUM_CH-1:0] chanD;
  logic [NUM_CH-1:0] prevD;

  assign rawBus = {prevIn, chanIn, auxIn, tmrIn};

  shutoff_sync #(
    .WIDTH  (RAW_W),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .d    (rawBus),
    .q    (syncBus)
  );

  assign tmrS  = syncBus[TMR_W-1:0];
  assign auxS  = syncBus[AUX_LO +: AUX_W];
  assign chanS = syncBus[CHAN_LO +: NUM_CH];
  assign prevS = syncBus[PREV_LO +: NUM_CH];

  // one-cycle history of synchronized edge inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanD <= '0;
      prevD <= '0;
    end else begin
      chanD <= chanS;
      prevD <= prevS;
    end
  end

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : gChan
    logic srcRaw;
    logic relHit;
    logic flagR;

    // source mux: codes 2..5 map onto aux lines in a rotated order
    always_comb begin
      unique case (srcSel[g])
        3'd0:    srcRaw = tmrS[0];
        3'd1:    srcRaw = tmrS[1];
        3'd2:    srcRaw = auxS[2];
        3'd3:    srcRaw = auxS[3];
        3'd4:    srcRaw = auxS[0];
        3'd5:    srcRaw = auxS[1];
        3'd6:    srcRaw = 1'b0;
        default: srcRaw = 1'b1;
      endcase
    end

    always_comb begin
      unique case (relEdge_t'(edgeSel[g]))
        REL_OWN_FALL:  relHit = chanD[g] & ~chanS[g];
        REL_OWN_RISE:  relHit = ~chanD[g] & chanS[g];
        REL_PREV_FALL: relHit = prevD[g] & ~prevS[g];
        default:       relHit = ~prevD[g] & prevS[g];
      endcase
    end

    assign stat[g] = '{srcActive: srcRaw ^ srcInv[g], relEdge: relHit};

    // set has priority over clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagR <= 1'b0;
      end else if (cmd[g].setFlag) begin
        flagR <= 1'b1;
      end else if (cmd[g].clrFlag) begin
        flagR <= 1'b0;
      end
    end

    assign flagQ[g] = flagR;
  end

endmodule

// File: rtl/shutoff_ctrl.sv
module shutoff_ctrl
  import shutoff_latch_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0][MODE_W-1:0] mode,
  input  logic [NUM_CH-1:0]             swRst,
  input  logic                          swWe,
  input  chanStat_t [NUM_CH-1:0]        stat,
  input  logic [NUM_CH-1:0]             flagQ,
  output flagCmd_t [NUM_CH-1:0]         cmd
);

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : gPol
    flagCmd_t c;
    logic     swClr;

    assign swClr = swRst[g] & swWe;

    always_comb begin
      c = '0;
      unique case (latchMode_t'(mode[g]))
        LATCH_OFF: begin
          c.setFlag = 1'b0;
          c.clrFlag = 1'b1;
        end
        LATCH_STICKY: begin
          c.setFlag = stat[g].srcActive;
          c.clrFlag = swClr;
        end
        LATCH_EDGE_REL: begin
          c.setFlag = stat[g].srcActive;
          c.clrFlag = stat[g].relEdge;
        end
        default: begin
          c.setFlag = stat[g].srcActive;
          c.clrFlag = ~stat[g].srcActive;
        end
      endcase
    end

    assign cmd[g] = c;

    // R3: disabled policy drives the flag low
    a_r3_off_clears: assert property (@(posedge clk) disable iff (!rstN)
      (mode[g] == 2'd0) |=> !flagQ[g]);

    // R4: sticky flag survives without a qualified clear
    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
      (mode[g] == 2'd1 && flagQ[g] && !(swRst[g] && swWe)) |=> flagQ[g]);

    // R5: qualified clear with inactive source releases
    a_r5_qualified_clear: assert property (@(posedge clk) disable iff (!rstN)
      (mode[g] == 2'd1 && swRst[g] && swWe && !stat[g].srcActive) |=> !flagQ[g]);

    // R6: edge policy holds until the selected edge
    a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rstN)
      (mode[g] == 2'd2 && flagQ[g] && !stat[g].relEdge) |=> flagQ[g]);

    // R8: following policy tracks the source one edge later
    a_r8_follow: assert property (@(posedge clk) disable iff (!rstN)
      (mode[g] == 2'd3) |=> (flagQ[g] == $past(stat[g].srcActive)));

    // R9: active source always wins in non-disabled policies
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      (mode[g] != 2'd0 && stat[g].srcActive) |=> flagQ[g]);
  end

endmodule

// File: rtl/shutoff_latch.sv
module shutoff_latch
  import shutoff_latch_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [TMR_W-1:0]              tmrIn,
  input  logic [AUX_W-1:0]              auxIn,
  input  logic [NUM_CH-1:0]             chanIn,
  input  logic [NUM_CH-1:0]             prevIn,
  input  logic [NUM_CH-1:0][SEL_W-1:0]  srcSel,
  input  logic [NUM_CH-1:0]             srcInv,
  input  logic [NUM_CH-1:0][MODE_W-1:0] mode,
  input  logic [NUM_CH-1:0][EDGE_W-1:0] edgeSel,
  input  logic [NUM_CH-1:0]             swRst,
  input  logic                          swWe,
  output logic [NUM_CH-1:0]             shutFlag
);

  flagCmd_t  [NUM_CH-1:0] cmd;
  chanStat_t [NUM_CH-1:0] stat;
  logic      [NUM_CH-1:0] flagQ;

  shutoff_datapath #(
    .NUM_CH      (NUM_CH),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .tmrIn   (tmrIn),
    .auxIn   (auxIn),
    .chanIn  (chanIn),
    .prevIn  (prevIn),
    .srcSel  (srcSel),
    .srcInv  (srcInv),
    .edgeSel (edgeSel),
    .cmd     (cmd),
    .stat    (stat),
    .flagQ   (flagQ)
  );

  shutoff_ctrl #(
    .NUM_CH (NUM_CH)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .mode  (mode),
    .swRst (swRst),
    .swWe  (swWe),
    .stat  (stat),
    .flagQ (flagQ),
    .cmd   (cmd)
  );

  assign shutFlag = flagQ;

endmodule

// File: tb/shutoff_latch_tb_top.sv
module shutoff_latch_tb_top;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]        tmrIn;
  logic [3:0]        auxIn;
  logic [N-1:0]      chanIn, prevIn, srcInv, swRst;
  logic              swWe;
  logic [N-1:0][2:0] srcSel;
  logic [N-1:0][1:0] mode, edgeSel;
  logic [N-1:0]      shutFlag;

  int checks = 0;
  int errors = 0;

  shutoff_latch #(.NUM_CH(N)) dut_i (
    .clk(clk), .rstN(rstN), .tmrIn(tmrIn), .auxIn(auxIn), .chanIn(chanIn),
    .prevIn(prevIn), .srcSel(srcSel), .srcInv(srcInv), .mode(mode),
    .edgeSel(edgeSel), .swRst(swRst), .swWe(swWe), .shutFlag(shutFlag)
  );

  task automatic check(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  // n rising edges, then park on the falling edge
  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic driveSrc(int sel, logic v);
    case (sel)
      0: tmrIn[0] = v;
      1: tmrIn[1] = v;
      2: auxIn[2] = v;
      3: auxIn[3] = v;
      4: auxIn[0] = v;
      5: auxIn[1] = v;
      default: ;
    endcase
  endtask

  task automatic quiet();
    tmrIn = '0; auxIn = '0; chanIn = '0; prevIn = '0;
    srcInv = '0; swRst = '0; swWe = 1'b0;
    mode = '0; edgeSel = '0;
    srcSel[0] = 3'd6; srcSel[1] = 3'd6;
  endtask

  task automatic t_reset();
    check("R11", "flag during reset", shutFlag[0] | shutFlag[1], 1'b0);
    rstN = 1'b1;
    step(1);
    check("R11", "flag after reset", shutFlag[0] | shutFlag[1], 1'b0);
  endtask

  task automatic t_sources();
    mode[0] = 2'd3;
    mode[1] = 2'd0;
    srcSel[1] = 3'd7;            // ch1 disabled with a constant-1 source
    for (int sel = 0; sel < 6; sel++) begin
      srcSel[0] = 3'(sel);
      tmrIn = '0; auxIn = '0;
      step(4);
      check("R1", $sformatf("sel %0d idle", sel), shutFlag[0], 1'b0);
      driveSrc(sel, 1'b1);
      step(2);
      check("R10", $sformatf("sel %0d early", sel), shutFlag[0], 1'b0);
      step(1);
      check("R1", $sformatf("sel %0d active", sel), shutFlag[0], 1'b1);
      srcInv[0] = 1'b1;
      step(1);
      check("R2", $sformatf("sel %0d inverted", sel), shutFlag[0], 1'b0);
      srcInv[0] = 1'b0;
      driveSrc(sel, 1'b0);
    end
    srcSel[0] = 3'd6;
    step(1);
    check("R1", "constant 0", shutFlag[0], 1'b0);
    srcSel[0] = 3'd7;
    step(1);
    check("R10", "constant 1 next edge", shutFlag[0], 1'b1);
    srcSel[0] = 3'd6; srcInv[0] = 1'b1;
    step(1);
    check("R2", "inverted constant 0", shutFlag[0], 1'b1);
    check("R3", "disabled channel with constant 1", shutFlag[1], 1'b0);
    quiet();
    step(2);
  endtask

  task automatic t_sticky();
    mode[0] = 2'd1; srcSel[0] = 3'd0;
    tmrIn[0] = 1'b1;
    step(3);
    check("R4", "sticky set", shutFlag[0], 1'b1);
    swRst[0] = 1'b1; swWe = 1'b1;
    step(1);
    check("R9", "clear while source active", shutFlag[0], 1'b1);
    swRst[0] = 1'b0; swWe = 1'b0;
    tmrIn[0] = 1'b0;
    step(5);
    check("R4", "held after source drops", shutFlag[0], 1'b1);
    swRst[0] = 1'b1;
    step(1);
    check("R5", "request without enable", shutFlag[0], 1'b1);
    swRst[0] = 1'b0; swWe = 1'b1;
    step(1);
    check("R5", "enable without request", shutFlag[0], 1'b1);
    swRst[1] = 1'b1;
    step(1);
    check("R5", "other channel request", shutFlag[0], 1'b1);
    swRst = '0; swRst[0] = 1'b1;
    step(1);
    check("R4", "qualified software clear", shutFlag[0], 1'b0);
    swRst = '0; swWe = 1'b0;
    // disabled policy drops a set flag
    tmrIn[0] = 1'b1;
    step(3);
    check("R4", "set again", shutFlag[0], 1'b1);
    mode[0] = 2'd0;
    step(1);
    check("R3", "disable clears", shutFlag[0], 1'b0);
    step(4);
    check("R3", "stays clear with source active", shutFlag[0], 1'b0);
    quiet();
    step(3);
  endtask

  task automatic setEdgeIn(int es, bit selected, logic v);
    if ((es < 2) == selected) chanIn[0] = v;
    else                      prevIn[0] = v;
  endtask

  task automatic t_edge(int es);
    logic rising;
    rising = (es % 2) == 1;
    mode[0] = 2'd2; srcSel[0] = 3'd4; edgeSel[0] = 2'(es);
    setEdgeIn(es, 1'b1, rising);
    setEdgeIn(es, 1'b0, 1'b0);
    step(4);
    auxIn[0] = 1'b1;
    step(3);
    check("R6", $sformatf("edge %0d set", es), shutFlag[0], 1'b1);
    auxIn[0] = 1'b0;
    step(4);
    check("R6", $sformatf("edge %0d held", es), shutFlag[0], 1'b1);
    setEdgeIn(es, 1'b0, 1'b1);
    step(4);
    setEdgeIn(es, 1'b0, 1'b0);
    step(4);
    check("R7", $sformatf("edge %0d other input", es), shutFlag[0], 1'b1);
    setEdgeIn(es, 1'b1, ~rising);
    step(4);
    check("R7", $sformatf("edge %0d wrong direction", es), shutFlag[0], 1'b1);
    setEdgeIn(es, 1'b1, rising);
    step(2);
    check("R10", $sformatf("edge %0d early", es), shutFlag[0], 1'b1);
    step(1);
    check("R6", $sformatf("edge %0d release", es), shutFlag[0], 1'b0);
    quiet();
    step(4);
  endtask

  task automatic t_set_wins();
    mode[0] = 2'd2; edgeSel[0] = 2'd1; srcSel[0] = 3'd1;
    step(4);
    tmrIn[1] = 1'b1;
    step(3);
    check("R6", "set by timer 1", shutFlag[0], 1'b1);
    chanIn[0] = 1'b1;
    step(4);
    check("R9", "edge during active source", shutFlag[0], 1'b1);
    tmrIn[1] = 1'b0;
    step(4);
    check("R6", "no edge after drop", shutFlag[0], 1'b1);
    chanIn[0] = 1'b0;
    step(4);
    check("R7", "falling not selected", shutFlag[0], 1'b1);
    chanIn[0] = 1'b1;
    step(3);
    check("R6", "rising releases", shutFlag[0], 1'b0);
    quiet();
    step(4);
  endtask

  task automatic t_follow();
    mode[1] = 2'd3; srcSel[1] = 3'd3; srcInv[1] = 1'b1;
    step(4);
    check("R8", "inverted idle is active", shutFlag[1], 1'b1);
    auxIn[3] = 1'b1;
    step(2);
    check("R10", "follow early", shutFlag[1], 1'b1);
    step(1);
    check("R8", "follow low", shutFlag[1], 1'b0);
    auxIn[3] = 1'b0;
    step(3);
    check("R8", "follow high", shutFlag[1], 1'b1);
    check("R3", "channel 0 idle", shutFlag[0], 1'b0);
    quiet();
    step(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    quiet();
    step(3);
    t_reset();
    t_sources();
    t_sticky();
    for (int es = 0; es < 4; es++) t_edge(es);
    t_set_wins();
    t_follow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule